// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-clock static RAM for on-chip use. Every address, data and control input is captured on the rising clock edge. A read returns its word through an output register, so data arrives one cycle after the request was registered. A 2-bit burst counter produces the later addresses of a four-beat group. Each step of the counter is gated by an advance input, and a mode input picks linear or interleaved beat order.

A burst can be opened by either of two start strobes. The processor-side strobe is honoured only while chip select 1 is active, and the cycle it opens is always a read. The controller-side strobe is honoured whenever it is asserted and may carry a write. A write covers the byte lanes whose selects are low while the lane-write enable is low. A global write covers all four lanes. The three chip selects gate the whole device: a start strobe that arrives with any select inactive closes the burst, and the output goes idle one registered cycle later. The data-out bus and its drive flag stand in for a shared bidirectional bus. The bus is driven only when output enable is low and the completing cycle was a read.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read registered at rising edge k is written into the output register at edge k+1. It is visible on `dout` from then on while `oe_n` is low.
- R2: A burst opens when `cstart_n` is low, or when `pstart_n` is low while `sel1_n` is low. The opening cycle accesses `addr` and resets the beat count to 0. `pstart_n` is ignored while `sel1_n` is high.
- R3: In a cycle with no start, the beat count goes up by one (modulo 4) when `step_n` is low. When `step_n` is high the count holds and the same word is accessed again.
- R4: With `order_il` low, beat k of a burst based at address B accesses the word whose upper address bits are B's and whose low 2 bits are (B[1:0]+k) mod 4.
- R5: With `order_il` high, beat k accesses address B with its low 2 bits XORed with k.
- R6: With `wall_n` high and `wlane_en_n` low, lane i (data bits [9i+8:9i]) is written exactly when `lane_sel_n[i]` is low. With `wlane_en_n` high, no lane is written. A cycle that writes no lane is a read.
- R7: `wall_n` low writes all four lanes, whatever `wlane_en_n` and `lane_sel_n` are.
- R8: A cycle opened by the processor-side strobe performs a read, even when the write controls request a write.
- R9: A start strobe that arrives while any select is inactive (`sel1_n` high, `sel2` low or `sel3_n` high) ends the burst. `dout` is 0 and `dq_drive` is low after the next edge, and later cycles without a start access nothing.
- R10: `dq_drive` is high, and `dout` carries data, only when `oe_n` is low and the last completed cycle was a read. Otherwise `dout` is 0.
- R11: A read of an address that follows a write to it returns the new lane data, with unwritten lanes unchanged.
- R12: During and right after reset, `dq_drive` is low, `dout` is 0, no burst is open and every word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Burst start address |
| pstart_n | input | 1 | Processor-side burst start, active low |
| cstart_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved |
| wall_n | input | 1 | Global write, all lanes, active low |
| wlane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | NLANE | Per-lane write selects, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | NLANE*LANE_W | Write data |
| dout | output | NLANE*LANE_W | Read data, 0 when not driven |
| dq_drive | output | 1 | High while the data bus would be driven |

## Verification
The bench aims at a burst based at an odd address, where linear and interleaved beat orders part ways: a design that swapped or fused the two orders reads the wrong words from beat 1 on. It starts a processor-side burst with a global write asserted. A design that honoured the write would overwrite memory and would leave the output undriven for that cycle. It holds the advance input high in the middle of a burst and raises chip select 1 under a processor-side strobe. A counter that stepped anyway, or a strobe that was not masked, shows up as a wrong word. A deselecting strobe that only cleared the output late would leave one extra driven beat. A read-after-write that took the stale word would return old data.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  // Low two address bits of a burst beat.
  // il=0: count added to the base (wraps inside the group of four).
  // il=1: count XORed into the base.
  function automatic logic [1:0] burst_low(input logic [1:0] base_lo,
                                           input logic [1:0] beat,
                                           input logic       il);
    return il ? (base_lo ^ beat) : (base_lo + beat);
  endfunction

endpackage

// File: rtl/pbs_burst_gen.sv
module pbs_burst_gen #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sel_ok,
  input  logic          step,
  input  logic          il,
  input  logic [AW-1:0] addr,
  output logic          active,
  output logic [1:0]    cnt,
  output logic [AW-1:0] base,
  output logic [AW-1:0] cur_addr
);
  import pbs_pkg::*;

  logic [1:0] cnt_nx;

  assign cnt_nx   = cnt + {1'b0, step};
  assign cur_addr = start ? addr
                          : {base[AW-1:2], burst_low(base[1:0], cnt_nx, il)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      base   <= '0;
    end else if (start) begin
      active <= sel_ok;
      base   <= addr;
      cnt    <= '0;
    end else if (active) begin
      cnt    <= cnt_nx;
    end
  end

endmodule

// File: rtl/pbs_lane_dec.sv
module pbs_lane_dec #(
  parameter int NLANE = 4
) (
  input  logic             wall_n,
  input  logic             wen_n,
  input  logic [NLANE-1:0] sel_n,
  input  logic             block,
  output logic [NLANE-1:0] lanes
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = !block && (!wall_n || (!wen_n && !sel_n[g]));
  end
endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
  parameter int AW     = 6,
  parameter int NLANE  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic                    s1_wr,
  input  logic [NLANE-1:0]        s1_lanes,
  input  logic [AW-1:0]           s1_addr,
  input  logic [NLANE*LANE_W-1:0] s1_data,
  output logic [NLANE*LANE_W-1:0] rd_q,
  output logic                    rd_vld
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NLANE; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
        rd_q[g*LANE_W +: LANE_W] <= '0;
      end else if (s1_valid) begin
        if (s1_wr && s1_lanes[g])
          bank[s1_addr] <= s1_data[g*LANE_W +: LANE_W];
        if (!s1_wr)
          rd_q[g*LANE_W +: LANE_W] <= bank[s1_addr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= s1_valid && !s1_wr;
  end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int AW     = 6,
  parameter int NLANE  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = NLANE * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             pstart_n,
  input  logic             cstart_n,
  input  logic             step_n,
  input  logic             order_il,
  input  logic             wall_n,
  input  logic             wlane_en_n,
  input  logic [NLANE-1:0] lane_sel_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dq_drive
);

  // named events
  logic sel_ok, p_start, c_start, start_evt, desel_evt, cont_evt;
  logic acc_valid, acc_wr;
  logic burst_active;
  logic [1:0]    burst_cnt;
  logic [AW-1:0] burst_base, cur_addr;
  logic [NLANE-1:0] acc_lanes;

  assign sel_ok    = !sel1_n && sel2 && !sel3_n;
  assign p_start   = !pstart_n && !sel1_n;
  assign c_start   = !cstart_n;
  assign start_evt = p_start || c_start;
  assign desel_evt = start_evt && !sel_ok;
  assign cont_evt  = !start_evt && burst_active;
  assign acc_valid = (start_evt && sel_ok) || cont_evt;
  assign acc_wr    = acc_valid && (|acc_lanes);

  pbs_burst_gen #(.AW(AW)) burst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .sel_ok   (sel_ok),
    .step     (!step_n),
    .il       (order_il),
    .addr     (addr),
    .active   (burst_active),
    .cnt      (burst_cnt),
    .base     (burst_base),
    .cur_addr (cur_addr)
  );

  pbs_lane_dec #(.NLANE(NLANE)) lane_i (
    .wall_n (wall_n),
    .wen_n  (wlane_en_n),
    .sel_n  (lane_sel_n),
    .block  (p_start),
    .lanes  (acc_lanes)
  );

  // request stage
  logic             s1_valid, s1_wr;
  logic [NLANE-1:0] s1_lanes;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    s1_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_lanes <= '0;
      s1_addr  <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= acc_valid;
      s1_wr    <= acc_wr;
      s1_lanes <= acc_lanes;
      s1_addr  <= cur_addr;
      s1_data  <= din;
    end
  end

  logic [DW-1:0] rd_q;
  logic          rd_vld;

  pbs_store #(.AW(AW), .NLANE(NLANE), .LANE_W(LANE_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_wr    (s1_wr),
    .s1_lanes (s1_lanes),
    .s1_addr  (s1_addr),
    .s1_data  (s1_data),
    .rd_q     (rd_q),
    .rd_vld   (rd_vld)
  );

  assign dq_drive = rd_vld && !oe_n;
  assign dout     = dq_drive ? rd_q : '0;

endmodule

// File: rtl/pbs_sram_chk.sv
module pbs_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_evt,
  input logic          desel_evt,
  input logic          p_start,
  input logic          cont_evt,
  input logic          step_n,
  input logic [1:0]    burst_cnt,
  input logic [AW-1:0] burst_base,
  input logic [AW-1:0] addr,
  input logic          s1_valid,
  input logic          s1_wr,
  input logic          rd_vld,
  input logic          dq_drive,
  input logic          acc_valid,
  input logic          acc_wr
);
  AST_PIPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_wr) |=> ##1 rd_vld); // R1
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !desel_evt) |=> (burst_cnt == 2'd0 && burst_base == $past(addr))); // R2
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_evt && step_n) |=> $stable(burst_cnt)); // R3
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_evt && !step_n) |=> (burst_cnt == $past(burst_cnt) + 2'd1)); // R3
  AST_PSTART_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (p_start && !desel_evt) |=> (s1_valid && !s1_wr)); // R8
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    desel_evt |=> ##1 !dq_drive); // R9
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_wr) |=> !dq_drive); // R10
endmodule

bind pipe_burst_sram pbs_sram_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_evt  (start_evt),
  .desel_evt  (desel_evt),
  .p_start    (p_start),
  .cont_evt   (cont_evt),
  .step_n     (step_n),
  .burst_cnt  (burst_cnt),
  .burst_base (burst_base),
  .addr       (addr),
  .s1_valid   (s1_valid),
  .s1_wr      (s1_wr),
  .rd_vld     (rd_vld),
  .dq_drive   (dq_drive),
  .acc_valid  (acc_valid),
  .acc_wr     (acc_wr)
);

// File: tb/pipe_burst_sram_tb_top.sv
module pipe_burst_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic pstart_n, cstart_n, step_n, order_il, wall_n, wlane_en_n;
  logic [NL-1:0] lane_sel_n;
  logic sel1_n, sel2, sel3_n, oe_n;
  logic [DW-1:0] din, dout;
  logic dq_drive;

  always #2 clk = ~clk;

  pipe_burst_sram #(.AW(AW), .NLANE(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .pstart_n(pstart_n),
    .cstart_n(cstart_n), .step_n(step_n), .order_il(order_il),
    .wall_n(wall_n), .wlane_en_n(wlane_en_n), .lane_sel_n(lane_sel_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dq_drive(dq_drive)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] m_mem [1 << AW];
  bit m_act;
  logic [AW-1:0] m_base;
  int m_cnt;
  bit m_s1v, m_s1w, m_rv;
  logic [NL-1:0] m_s1l;
  logic [AW-1:0] m_s1a;
  logic [DW-1:0] m_s1d, m_rq;

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k, input bit il);
    logic [AW-1:0] kk = AW'(k & 3);
    if (il) return b ^ kk;
    return (b & ~AW'(3)) | ((b + kk) & AW'(3));
  endfunction

  task automatic model_step();
    bit sel, ps, cs, av;
    logic [AW-1:0] a;
    logic [NL-1:0] ln;
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
      m_act = 0; m_base = '0; m_cnt = 0;
      m_s1v = 0; m_s1w = 0; m_s1l = '0; m_s1a = '0; m_s1d = '0;
      m_rv = 0; m_rq = '0;
      return;
    end
    // completion stage
    if (m_s1v && m_s1w) begin
      for (int l = 0; l < NL; l++)
        if (m_s1l[l]) m_mem[m_s1a][l*LW +: LW] = m_s1d[l*LW +: LW];
      m_rv = 0;
    end else if (m_s1v) begin
      m_rq = m_mem[m_s1a];
      m_rv = 1;
    end else m_rv = 0;
    // request stage
    sel = !sel1_n && sel2 && !sel3_n;
    ps = !pstart_n && !sel1_n;
    cs = !cstart_n;
    av = 0; a = '0;
    if (ps || cs) begin
      av = sel; a = addr;
      m_act = sel; m_base = addr; m_cnt = 0;
    end else if (m_act) begin
      if (!step_n) m_cnt = (m_cnt + 1) % 4;
      av = 1; a = exp_addr(m_base, m_cnt, order_il);
    end
    if (ps) ln = '0;
    else if (!wall_n) ln = '1;
    else if (!wlane_en_n) ln = ~lane_sel_n;
    else ln = '0;
    m_s1v = av; m_s1w = av && (ln != '0); m_s1l = ln; m_s1a = a; m_s1d = din;
  endtask

  task automatic cmp(input string tag);
    bit ed = m_rv && !oe_n;
    logic [DW-1:0] eo = ed ? m_rq : '0;
    n_cmp++;
    if (dq_drive !== ed) begin
      n_bad++;
      $display("FAIL %s dq_drive actual=%0b expected=%0b", tag, dq_drive, ed);
    end
    n_cmp++;
    if (dout !== eo) begin
      n_bad++;
      $display("FAIL %s dout actual=%h expected=%h", tag, dout, eo);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic idle();
    pstart_n = 1; cstart_n = 1; step_n = 1; wall_n = 1; wlane_en_n = 1;
    lane_sel_n = '1; sel1_n = 0; sel2 = 1; sel3_n = 0; oe_n = 0;
  endtask

  task automatic cwrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    idle(); cstart_n = 0; addr = a; wall_n = 0; din = d;
    tick(tag);
    idle();
  endtask

  task automatic cread(input logic [AW-1:0] a, input string tag);
    idle(); cstart_n = 0; addr = a;
    tick(tag);
    idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; addr = '0; din = '0; order_il = 0;
    idle();
    @(negedge clk);
    repeat (3) tick("R12");
    rst_n = 1;
    tick("R12");
    cread(6'd3, "R12");
    tick("R12");

    // R7 global write fill, R11 read back
    for (int i = 8; i < 16; i++) cwrite(AW'(i), DW'(36'h100000000 + i * 36'h011), "R7");
    cread(6'd9, "R11"); tick("R11");

    // R6 lane writes: lanes 0 and 2
    idle(); cstart_n = 0; addr = 6'd5; wlane_en_n = 0; lane_sel_n = 4'b1010;
    din = 36'h1_2345_6789; tick("R6"); idle();
    cread(6'd5, "R6"); tick("R6");
    // R6 lane selects without enable: no write, read instead
    idle(); cstart_n = 0; addr = 6'd5; lane_sel_n = 4'b0000; din = 36'hF_FFFF_FFFF;
    tick("R6"); idle(); tick("R6");
    // R7 global write overrides disabled lanes
    idle(); cstart_n = 0; addr = 6'd5; wall_n = 0; wlane_en_n = 1; lane_sel_n = 4'b1111;
    din = 36'hA_BCDE_F012; tick("R7"); idle();
    cread(6'd5, "R7"); tick("R11");

    // R8 processor start with global write: read, no write
    idle(); pstart_n = 0; addr = 6'd9; wall_n = 0; din = 36'h0; tick("R8"); idle();
    tick("R8");
    cread(6'd9, "R8"); tick("R8");

    // R4 linear burst from 9
    order_il = 0;
    idle(); pstart_n = 0; addr = 6'd9; tick("R4");
    idle(); step_n = 0;
    repeat (4) tick("R4");
    // R5 interleaved burst from 9
    order_il = 1;
    idle(); cstart_n = 0; addr = 6'd9; tick("R5");
    idle(); step_n = 0;
    repeat (4) tick("R5");

    // R3 suspend mid burst
    order_il = 0;
    idle(); cstart_n = 0; addr = 6'd12; tick("R3");
    idle(); step_n = 0; tick("R3");
    idle(); step_n = 1; tick("R3"); tick("R3");
    idle(); step_n = 0; tick("R3");

    // R2 processor strobe ignored while sel1 high (burst continues)
    idle(); sel1_n = 1; pstart_n = 0; addr = 6'd0; step_n = 0; tick("R2");
    idle(); step_n = 0; tick("R2"); tick("R2");

    // R9 deselect with sel2 low, then idle continuation cycles
    idle(); cstart_n = 0; sel2 = 0; addr = 6'd10; tick("R9");
    idle(); step_n = 0; tick("R9"); tick("R9"); tick("R9");

    // R10 output enable high, and write cycle not driving
    idle(); cstart_n = 0; addr = 6'd11; oe_n = 1; tick("R10");
    oe_n = 1; tick("R10");
    oe_n = 0; tick("R10");
    cwrite(6'd14, 36'h5_5555_5555, "R10"); tick("R10");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      pstart_n   = ($urandom % 6) != 0;
      cstart_n   = ($urandom % 5) != 0;
      step_n     = $urandom % 2;
      order_il   = ($urandom % 8) == 0 ? ~order_il : order_il;
      wall_n     = ($urandom % 6) != 0;
      wlane_en_n = ($urandom % 3) != 0;
      lane_sel_n = NL'($urandom);
      sel1_n     = ($urandom % 8) == 0;
      sel2       = ($urandom % 10) != 0;
      sel3_n     = ($urandom % 10) == 0;
      oe_n       = ($urandom % 5) == 0;
      addr       = AW'($urandom);
      din        = DW'({$urandom, $urandom});
      tick("R1");
    end
    idle(); repeat (3) tick("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule